// File: doc/BRIEF.md
# Two-Operand NaN Propagation Selector

This block decides which result a two-input floating-point operation returns when at least one of its operands is Not-a-Number. It looks at two single-precision words and sorts each one into one of three classes: signaling NaN, quiet NaN, or ordinary value. Infinities, zeros and finite numbers all count as ordinary values. It then applies one of five propagation rules, chosen at run time, to pick one operand. The picked operand is returned in quiet form, together with a flag that reports an invalid operation.

The arithmetic unit that owns the operation instantiates the selector next to its datapath. When `res_valid_o` is high, the arithmetic unit takes `res_o` in place of its own result. It ORs `invalid_o` into its exception state. A default-NaN control replaces the picked operand with a single canonical quiet NaN.

The block is purely combinational. The exponent and fraction widths are parameters, and the requirements below are stated for the default single-precision format: 8 exponent bits and 23 fraction bits, with the sign in bit 31.

Top module: `nanprop_sel`

## Requirements
- R1: An operand is a NaN when its exponent field (bits 30:23) is all ones and its fraction (bits 22:0) is non-zero. A NaN is quiet when fraction bit 22 is 1 and signaling when it is 0. Infinities and all other values are ordinary.
- R2: With rule code 0 (signaling first, a before b), the result is taken from a if a is signaling. Otherwise it comes from b if b is signaling. Otherwise it comes from a if a is quiet, and otherwise from b.
- R3: With rule code 1 (signaling first, b before a), the result is taken from b if b is signaling. Otherwise it comes from a if a is signaling. Otherwise it comes from b if b is quiet, and otherwise from a.
- R4: With rule code 2, the result comes from a if a is any NaN, otherwise from b. With rule code 3, the result comes from b if b is any NaN, otherwise from a.
- R5: With rule code 4 (largest significand), a NaN paired with an ordinary value yields the NaN. A signaling NaN paired with a quiet NaN yields the quiet one. When both are signaling or both are quiet, the operand whose 23-bit fraction is larger, read as an unsigned number, is chosen.
- R6: Under rule code 4, when both operands are in the same NaN class and their fractions are equal, the operand with sign bit 0 wins over the one with sign bit 1. If the two signs are equal, b is chosen.
- R7: Rule codes 5, 6 and 7 behave exactly as rule code 0.
- R8: The result equals the selected operand with fraction bit 22 forced to 1. A signaling operand therefore leaves quieted, and its sign, exponent and other fraction bits are unchanged.
- R9: When `dflt_nan_i` is 1 and a NaN is present, `res_o` is 0x7FC00000 for every rule code.
- R10: `invalid_o` is 1 exactly when at least one operand is a signaling NaN. This holds whether or not default-NaN mode is on.
- R11: `res_valid_o` is 1 exactly when at least one operand is a NaN. When it is 0, `res_o` carries no meaning.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 32 | First operand (a) |
| opb_i | input | 32 | Second operand (b) |
| rule_i | input | 3 | Propagation rule code (0 to 4; 5 to 7 act as 0) |
| dflt_nan_i | input | 1 | Return the canonical quiet NaN instead of an operand |
| res_o | output | 32 | Propagated NaN |
| res_valid_o | output | 1 | At least one operand is a NaN |
| invalid_o | output | 1 | At least one operand is a signaling NaN |

## Verification
The bench sweeps every pairing of a set of operands that covers both signs. The set includes zero, a finite number, both infinities, and quiet and signaling NaNs whose fractions are equal, smaller and larger. Each pairing is applied under all eight rule codes, with default-NaN mode both off and on.

Each kind of design error shows up somewhere in this sweep:
- Treating infinity as a NaN makes `res_valid_o` rise for an infinity/number pair.
- A design that loses the quiet-over-signaling preference of rule 4 returns the signaling operand.
- A design that reverses the sign tie-break returns the negative twin.
- A design that skips silencing leaves fraction bit 22 clear.
- A design that drops the invalid flag in default-NaN mode misses signaling operands there.
- A design that decodes the unused rule codes wrongly diverges from rule 0 on mixed signaling and quiet pairs.

// File: rtl/nanprop_pkg.sv
package nanprop_pkg;

    // Operand class after inspection of exponent and fraction
    typedef enum logic [1:0] {
        CLS_NUM  = 2'd0,
        CLS_QNAN = 2'd1,
        CLS_SNAN = 2'd2
    } nan_cls_e;

    // Propagation rule codes; codes 5..7 fall back to RULE_SIG_AB
    typedef enum logic [2:0] {
        RULE_SIG_AB = 3'd0,
        RULE_SIG_BA = 3'd1,
        RULE_ANY_A  = 3'd2,
        RULE_ANY_B  = 3'd3,
        RULE_LARGE  = 3'd4
    } nan_rule_e;

endpackage

// File: rtl/nanprop_classify.sv
module nanprop_classify
    import nanprop_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W-1:0]  exp_i,
    input  logic [FRAC_W-1:0] frac_i,
    output nan_cls_e          cls_o
);
    logic exp_ones;
    logic frac_nz;
    logic quiet_bit;

    assign exp_ones  = &exp_i;
    assign frac_nz   = |frac_i;
    assign quiet_bit = frac_i[FRAC_W-1];

    always_comb begin
        if (!(exp_ones && frac_nz)) begin
            cls_o = CLS_NUM;
        end else if (quiet_bit) begin
            cls_o = CLS_QNAN;
        end else begin
            cls_o = CLS_SNAN;
        end
    end
endmodule

// File: rtl/nanprop_pick.sv
module nanprop_pick
    import nanprop_pkg::*;
#(
    parameter int FRAC_W = 23
) (
    input  nan_cls_e          cls_a_i,
    input  nan_cls_e          cls_b_i,
    input  logic [FRAC_W-1:0] frac_a_i,
    input  logic [FRAC_W-1:0] frac_b_i,
    input  logic              sign_a_i,
    input  logic              sign_b_i,
    input  logic [2:0]        rule_i,
    output logic              pick_b_o
);
    logic a_s, a_q, b_s, b_q, a_nan, b_nan;
    logic a_larger;

    assign a_s   = (cls_a_i == CLS_SNAN);
    assign a_q   = (cls_a_i == CLS_QNAN);
    assign b_s   = (cls_b_i == CLS_SNAN);
    assign b_q   = (cls_b_i == CLS_QNAN);
    assign a_nan = a_s | a_q;
    assign b_nan = b_s | b_q;

    // Larger fraction wins; on a tie, positive a beats negative b
    assign a_larger = (frac_a_i > frac_b_i) ||
                      ((frac_a_i == frac_b_i) && !sign_a_i && sign_b_i);

    always_comb begin
        unique case (rule_i)
            RULE_SIG_BA: begin
                if (b_s)      pick_b_o = 1'b1;
                else if (a_s) pick_b_o = 1'b0;
                else          pick_b_o = b_q;
            end
            RULE_ANY_A: begin
                pick_b_o = !a_nan;
            end
            RULE_ANY_B: begin
                pick_b_o = b_nan;
            end
            RULE_LARGE: begin
                if (a_s) begin
                    pick_b_o = b_s ? !a_larger : b_q;
                end else if (a_q) begin
                    pick_b_o = b_q ? !a_larger : 1'b0;
                end else begin
                    pick_b_o = 1'b1;
                end
            end
            default: begin
                if (a_s)      pick_b_o = 1'b0;
                else if (b_s) pick_b_o = 1'b1;
                else          pick_b_o = !a_q;
            end
        endcase
    end
endmodule

// File: rtl/nanprop_out.sv
module nanprop_out
    import nanprop_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] opa_i,
    input  logic [EXP_W+FRAC_W:0] opb_i,
    input  logic                  pick_b_i,
    input  logic                  dflt_nan_i,
    output logic [EXP_W+FRAC_W:0] res_o
);
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam logic [WORD_W-1:0] QBIT =
        {{(WORD_W-1){1'b0}}, 1'b1} << (FRAC_W - 1);
    localparam logic [WORD_W-1:0] DFLT =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic [WORD_W-1:0] chosen;

    assign chosen = pick_b_i ? opb_i : opa_i;

    always_comb begin
        if (dflt_nan_i) begin
            res_o = DFLT;
        end else begin
            res_o = chosen | QBIT;
        end
    end
endmodule

// File: rtl/nanprop_sel.sv
module nanprop_sel
    import nanprop_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] opa_i,
    input  logic [EXP_W+FRAC_W:0] opb_i,
    input  logic [2:0]            rule_i,
    input  logic                  dflt_nan_i,
    output logic [EXP_W+FRAC_W:0] res_o,
    output logic                  res_valid_o,
    output logic                  invalid_o
);
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam int N_OPS  = 2;

    logic [N_OPS-1:0][WORD_W-1:0] ops;
    nan_cls_e                     cls [N_OPS];
    logic                         pick_b;

    assign ops = {opb_i, opa_i};

    for (genvar g = 0; g < N_OPS; g++) begin : g_cls
        nanprop_classify #(
            .EXP_W  (EXP_W),
            .FRAC_W (FRAC_W)
        ) u_classify (
            .exp_i  (ops[g][WORD_W-2:FRAC_W]),
            .frac_i (ops[g][FRAC_W-1:0]),
            .cls_o  (cls[g])
        );
    end

    nanprop_pick #(
        .FRAC_W (FRAC_W)
    ) u_pick (
        .cls_a_i  (cls[0]),
        .cls_b_i  (cls[1]),
        .frac_a_i (opa_i[FRAC_W-1:0]),
        .frac_b_i (opb_i[FRAC_W-1:0]),
        .sign_a_i (opa_i[WORD_W-1]),
        .sign_b_i (opb_i[WORD_W-1]),
        .rule_i   (rule_i),
        .pick_b_o (pick_b)
    );

    nanprop_out #(
        .EXP_W  (EXP_W),
        .FRAC_W (FRAC_W)
    ) u_out (
        .opa_i      (opa_i),
        .opb_i      (opb_i),
        .pick_b_i   (pick_b),
        .dflt_nan_i (dflt_nan_i),
        .res_o      (res_o)
    );

    assign res_valid_o = (cls[0] != CLS_NUM) || (cls[1] != CLS_NUM);
    assign invalid_o   = (cls[0] == CLS_SNAN) || (cls[1] == CLS_SNAN);
endmodule

// File: rtl/nanprop_sel_chk.sv
module nanprop_sel_chk #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input logic [EXP_W+FRAC_W:0] opa_i,
    input logic [EXP_W+FRAC_W:0] opb_i,
    input logic                  dflt_nan_i,
    input logic [EXP_W+FRAC_W:0] res_o,
    input logic                  res_valid_o,
    input logic                  invalid_o
);
    localparam int WORD_W = 1 + EXP_W + FRAC_W;
    localparam logic [WORD_W-1:0] QBIT =
        {{(WORD_W-1){1'b0}}, 1'b1} << (FRAC_W - 1);
    localparam logic [WORD_W-1:0] DFLT =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic a_nan, b_nan, a_sig, b_sig;

    assign a_nan = (&opa_i[WORD_W-2:FRAC_W]) && (|opa_i[FRAC_W-1:0]);
    assign b_nan = (&opb_i[WORD_W-2:FRAC_W]) && (|opb_i[FRAC_W-1:0]);
    assign a_sig = a_nan && !opa_i[FRAC_W-1];
    assign b_sig = b_nan && !opb_i[FRAC_W-1];

    always_comb begin
        p_valid_match_r11: assert (res_valid_o == (a_nan || b_nan));
        p_invalid_match_r10: assert (invalid_o == (a_sig || b_sig));
        if (res_valid_o) begin
            p_result_quiet_r8: assert ((&res_o[WORD_W-2:FRAC_W]) && res_o[FRAC_W-1]);
        end
        if (res_valid_o && dflt_nan_i) begin
            p_default_nan_r9: assert (res_o == DFLT);
        end
        if (res_valid_o && !dflt_nan_i) begin
            p_from_operand_r2: assert ((res_o == (opa_i | QBIT)) || (res_o == (opb_i | QBIT)));
        end
    end
endmodule

bind nanprop_sel nanprop_sel_chk #(
    .EXP_W  (EXP_W),
    .FRAC_W (FRAC_W)
) u_nanprop_sel_chk (
    .opa_i       (opa_i),
    .opb_i       (opb_i),
    .dflt_nan_i  (dflt_nan_i),
    .res_o       (res_o),
    .res_valid_o (res_valid_o),
    .invalid_o   (invalid_o)
);

// File: tb/test_nanprop_sel.sv
module test_nanprop_sel;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] opa = 32'h0;
    logic [31:0] opb = 32'h0;
    logic [2:0]  rule = 3'd0;
    logic        dn = 1'b0;
    logic [31:0] res;
    logic        res_valid;
    logic        invalid;

    int n_vec  = 0;
    int n_fail = 0;
    int cycles = 0;

    always #10 clk = ~clk;   // 50 MHz

    nanprop_sel i_nanprop_sel (
        .opa_i       (opa),
        .opb_i       (opb),
        .rule_i      (rule),
        .dflt_nan_i  (dn),
        .res_o       (res),
        .res_valid_o (res_valid),
        .invalid_o   (invalid)
    );

    function automatic logic [31:0] pattern(input int i);
        case (i)
            0:  pattern = 32'h0000_0000;  // zero
            1:  pattern = 32'h3F80_0000;  // 1.0
            2:  pattern = 32'h7F80_0000;  // +inf
            3:  pattern = 32'hFF80_0000;  // -inf
            4:  pattern = 32'h7FC0_0000;  // qNaN +
            5:  pattern = 32'hFFC0_0000;  // qNaN - same fraction
            6:  pattern = 32'h7FC0_0005;  // qNaN larger
            7:  pattern = 32'h7FFF_FFFF;  // qNaN max
            8:  pattern = 32'h7F80_0001;  // sNaN +
            9:  pattern = 32'hFF80_0001;  // sNaN - same fraction
            10: pattern = 32'h7FA0_0000;  // sNaN larger
            default: pattern = 32'hFF81_2345;
        endcase
    endfunction

    // class: 0 ordinary, 1 quiet, 2 signaling (R1)
    function automatic int kind(input logic [31:0] v);
        if (v[30:23] != 8'hFF || v[22:0] == 23'd0) return 0;
        return v[22] ? 1 : 2;
    endfunction

    // returns 1 when b is the source
    function automatic bit ref_pick(input logic [31:0] a, input logic [31:0] b, input int r);
        int ka = kind(a);
        int kb = kind(b);
        bit big_a;
        case (r)
            1: return (kb == 2) ? 1'b1 : (ka == 2) ? 1'b0 : (kb == 1);          // R3
            2: return (ka == 0);                                               // R4
            3: return (kb != 0);                                               // R4
            4: begin                                                           // R5, R6
                if (a[22:0] != b[22:0]) big_a = (a[22:0] > b[22:0]);
                else                    big_a = (a[31] == 1'b0) && (b[31] == 1'b1);
                if (ka == 0) return 1'b1;
                if (kb == 0) return 1'b0;
                if (ka != kb) return (kb == 1);
                return !big_a;
            end
            default: return (ka == 2) ? 1'b0 : (kb == 2) ? 1'b1 : (ka != 1);  // R2, R7
        endcase
    endfunction

    task automatic apply(input logic [31:0] a, input logic [31:0] b,
                         input logic [2:0] r, input logic d);
        logic [31:0] src;
        logic [31:0] exp_res;
        bit          exp_val, exp_inv, pb;
        string       tag;
        @(posedge clk);
        opa <= a; opb <= b; rule <= r; dn <= d;
        @(negedge clk);
        n_vec++;
        exp_val = (kind(a) != 0) || (kind(b) != 0);
        exp_inv = (kind(a) == 2) || (kind(b) == 2);
        if (res_valid !== exp_val) begin
            n_fail++;
            $display("FAIL R11/R1 valid a=%h b=%h got %0b exp %0b", a, b, res_valid, exp_val);
        end
        if (invalid !== exp_inv) begin
            n_fail++;
            $display("FAIL R10 invalid a=%h b=%h dn=%0b got %0b exp %0b", a, b, d, invalid, exp_inv);
        end
        if (exp_val) begin
            pb  = ref_pick(a, b, int'(r));
            src = pb ? b : a;
            if (d) begin
                exp_res = 32'h7FC0_0000; tag = "R9";
            end else begin
                exp_res = src | 32'h0040_0000;
                if (kind(src) == 2)                         tag = "R8";
                else if (r >= 3'd5)                         tag = "R7";
                else if (r == 3'd4 && a[22:0] == b[22:0])   tag = "R6";
                else if (r == 3'd4)                         tag = "R5";
                else if (r == 3'd2 || r == 3'd3)            tag = "R4";
                else if (r == 3'd1)                         tag = "R3";
                else                                        tag = "R2";
            end
            if (res !== exp_res) begin
                n_fail++;
                $display("FAIL %s a=%h b=%h rule=%0d dn=%0b got %h exp %h",
                         tag, a, b, r, d, res, exp_res);
            end
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // idle state after reset: zero operands give no result, no flag (R11)
        n_vec++;
        if (res_valid !== 1'b0 || invalid !== 1'b0) begin
            n_fail++;
            $display("FAIL R11 idle got valid=%0b inv=%0b exp 0 0", res_valid, invalid);
        end
        // directed: infinity is not a NaN (R1)
        apply(32'h7F80_0000, 32'h3F80_0000, 3'd0, 1'b0);
        // directed: sNaN silenced keeps payload (R8)
        apply(32'hFF81_2345, 32'h0000_0000, 3'd0, 1'b0);
        // directed: sign tie-break under rule 4 (R6)
        apply(32'hFFC0_0000, 32'h7FC0_0000, 3'd4, 1'b0);
        // sweep all pairings, rules and modes: R2..R10
        for (int d = 0; d < 2; d++) begin
            for (int r = 0; r < 8; r++) begin
                for (int i = 0; i < 12; i++) begin
                    for (int j = 0; j < 12; j++) begin
                        apply(pattern(i), pattern(j), 3'(r), 1'(d));
                    end
                end
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog expired after %0d cycles, expected completion", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

endmodule